// File: doc/BRIEF.md
# Halfword Pack Execution Unit

This execution-stage datapath forms a 32-bit result by joining one fixed halfword of the first source operand with one halfword of a shifted copy of the second source operand. Two variants exist. The bottom-top variant keeps the low half of the first operand and takes the high half of the second operand after a logical left shift. The top-bottom variant keeps the high half of the first operand and takes the low half of the second operand after a sign-extending right shift.

Each operation arrives with a valid strobe, a condition code that is tested against the current N, Z, C and V flags, and the three register indices it names. The unit checks the encoding restrictions and raises an illegal flag for a forbidden combination. The result, a write enable and the illegal flag are all registered one clock after the strobe. The unit never drives the flags. Fetch, full-word decode and the register file sit outside the block.

Top module: `hpk_unit`

## Requirements
- R1: With `pk_top_bot`=0 (bottom-top), `res_q[15:0]` equals `src_a[15:0]` and `res_q[31:16]` equals bits [31:16] of `src_b` shifted left logically by `sh_field` (0 to 31), with zeros filled in.
- R2: In bottom-top, `sh_field`=0 passes the top half of `src_b` unchanged, and `sh_field`=16 moves the bottom half of `src_b` into `res_q[31:16]`.
- R3: With `pk_top_bot`=1 (top-bottom), `res_q[31:16]` equals `src_a[31:16]` and `res_q[15:0]` equals bits [15:0] of `src_b` shifted right arithmetically by `sh_field` (1 to 31), with copies of `src_b[31]` filled in. A shift of 16 places the top half of `src_b` in the low half.
- R4: In top-bottom, `sh_field`=0 means a shift of 32, so every bit of `res_q[15:0]` equals `src_b[31]`.
- R5: In top-bottom, the shift-type input `sh_is_asr` has no effect on the result, the write enable or the illegal flag.
- R6: Bottom-top together with `sh_is_asr`=1 is illegal: `illegal_q`=1 and `wr_en_q`=0 in the following cycle.
- R7: A value of 15 on any of `rd_idx`, `rn_idx` or `rm_idx` is illegal (`illegal_q`=1, `wr_en_q`=0).
- R8: A value of 13 on any index is illegal only when `compact_enc`=1. With `compact_enc`=0 it is legal.
- R9: `cond_code` is tested against `flags_nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 always. A failing condition gives `wr_en_q`=0 with `illegal_q` unaffected.
- R10: The outputs register one cycle after a clock edge at which `in_valid`=1, and `res_q` loads the packed value even when the operation is illegal or its condition fails. After a clock edge with `in_valid`=0, `wr_en_q`=0, `illegal_q`=0 and `res_q` holds its value.
- R11: A synchronous active-high `rst` clears `res_q`, `wr_en_q` and `illegal_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src_a | input | 32 | First operand; supplies the kept halfword |
| src_b | input | 32 | Second operand; shifted before its halfword is taken |
| pk_top_bot | input | 1 | 0 bottom-top variant, 1 top-bottom variant |
| sh_field | input | 5 | Shift amount field |
| sh_is_asr | input | 1 | Shift type bit: 1 arithmetic right, 0 logical left |
| cond_code | input | 4 | Condition code |
| flags_nzcv | input | 4 | Current N, Z, C, V flags (N in bit 3) |
| rd_idx | input | 4 | Destination register index |
| rn_idx | input | 4 | First-operand register index |
| rm_idx | input | 4 | Second-operand register index |
| compact_enc | input | 1 | Compact encoding mode selected |
| res_q | output | 32 | Registered packed result |
| wr_en_q | output | 1 | Registered result-commit enable |
| illegal_q | output | 1 | Registered illegal-encoding flag |

## Verification
The embedded properties check on every cycle that the kept halfword of the first operand reaches the result, that the bottom-top/arithmetic-shift combination and index 15 always raise the illegal flag and block the write, and that an idle cycle clears the strobes and holds the result. The exact values of the shifted halfwords need the bench's scenarios: the shift-of-32 encoding, sign filling, the shift-type bit being ignored in top-bottom mode, the full condition table under different flag patterns, and the index-13 rule that depends on the mode. Mid-run reset is also covered only by the scenarios.

// File: rtl/hpk_pkg.sv
`timescale 1ns/1ps
package hpk_pkg;

    typedef enum logic {
        PK_BOT_TOP = 1'b0,
        PK_TOP_BOT = 1'b1
    } pk_variant_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/hpk_shift_pack.sv
`timescale 1ns/1ps
module hpk_shift_pack
    import hpk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         opa,
    input  logic [DATA_W-1:0]         opb,
    input  pk_variant_e               variant,
    input  logic [$clog2(DATA_W)-1:0] shamt,
    output logic [DATA_W-1:0]         packed_word
);
    localparam int SH_W   = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;

    logic [SH_W:0]              rs_amt;
    logic [DATA_W-1:0]          lsl_word;
    logic signed [DATA_W-1:0]   opb_s;
    logic [DATA_W-1:0]          asr_word;
    logic                       unused_halves;

    // Right shift: a zero field stands for a full-width shift.
    assign rs_amt   = (shamt == '0) ? (SH_W+1)'(DATA_W) : {1'b0, shamt};
    assign lsl_word = opb << shamt;
    assign opb_s    = $signed(opb);
    assign asr_word = opb_s >>> rs_amt;

    assign unused_halves = ^{lsl_word[HALF_W-1:0], asr_word[DATA_W-1:HALF_W]};

    always_comb begin
        unique case (variant)
            PK_BOT_TOP: packed_word = {lsl_word[DATA_W-1:HALF_W], opa[HALF_W-1:0]};
            PK_TOP_BOT: packed_word = {opa[DATA_W-1:HALF_W], asr_word[HALF_W-1:0]};
            default:    packed_word = '0;
        endcase
    end

endmodule

// File: rtl/hpk_cond_eval.sv
`timescale 1ns/1ps
module hpk_cond_eval
    import hpk_pkg::*;
(
    input  logic [3:0] cond_in,
    input  logic [3:0] flags_in,
    output logic       cond_pass
);
    nzcv_t f;
    cond_e cc;

    assign f  = nzcv_t'(flags_in);
    assign cc = cond_e'(cond_in);

    always_comb begin
        unique case (cc)
            CC_EQ:   cond_pass = f.z;
            CC_NE:   cond_pass = !f.z;
            CC_CS:   cond_pass = f.c;
            CC_CC:   cond_pass = !f.c;
            CC_MI:   cond_pass = f.n;
            CC_PL:   cond_pass = !f.n;
            CC_VS:   cond_pass = f.v;
            CC_VC:   cond_pass = !f.v;
            CC_HI:   cond_pass = f.c && !f.z;
            CC_LS:   cond_pass = !f.c || f.z;
            CC_GE:   cond_pass = (f.n == f.v);
            CC_LT:   cond_pass = (f.n != f.v);
            CC_GT:   cond_pass = !f.z && (f.n == f.v);
            CC_LE:   cond_pass = f.z || (f.n != f.v);
            CC_AL:   cond_pass = 1'b1;
            CC_NV:   cond_pass = 1'b1;
            default: cond_pass = 1'b1;
        endcase
    end

endmodule

// File: rtl/hpk_legal_chk.sv
`timescale 1ns/1ps
module hpk_legal_chk
    import hpk_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int NUM_IDX = 3,
    parameter int PC_IDX  = 15,
    parameter int SP_IDX  = 13
) (
    input  logic [NUM_IDX*IDX_W-1:0] idx_flat,
    input  logic                     compact,
    input  pk_variant_e              variant,
    input  logic                     arith,
    output logic                     illegal
);
    logic [NUM_IDX-1:0] bad_idx;

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        logic [IDX_W-1:0] idx;
        assign idx        = idx_flat[g*IDX_W +: IDX_W];
        assign bad_idx[g] = (idx == IDX_W'(PC_IDX)) ||
                            (compact && (idx == IDX_W'(SP_IDX)));
    end

    assign illegal = (|bad_idx) || ((variant == PK_BOT_TOP) && arith);

endmodule

// File: rtl/hpk_unit.sv
`timescale 1ns/1ps
module hpk_unit
    import hpk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15,
    parameter int SP_IDX = 13
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            src_a,
    input  logic [DATA_W-1:0]            src_b,
    input  logic                         pk_top_bot,
    input  logic [$clog2(DATA_W)-1:0]    sh_field,
    input  logic                         sh_is_asr,
    input  logic [3:0]                   cond_code,
    input  logic [3:0]                   flags_nzcv,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [IDX_W-1:0]             rn_idx,
    input  logic [IDX_W-1:0]             rm_idx,
    input  logic                         compact_enc,
    output logic [DATA_W-1:0]            res_q,
    output logic                         wr_en_q,
    output logic                         illegal_q
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int NUM_IDX = 3;

    pk_variant_e        variant;
    logic [DATA_W-1:0]  packed_c;
    logic               cond_ok;
    logic               illegal_c;

    assign variant = pk_variant_e'(pk_top_bot);

    hpk_shift_pack #(.DATA_W(DATA_W)) u_pack (
        .opa         (src_a),
        .opb         (src_b),
        .variant     (variant),
        .shamt       (sh_field),
        .packed_word (packed_c)
    );

    hpk_cond_eval u_cond (
        .cond_in   (cond_code),
        .flags_in  (flags_nzcv),
        .cond_pass (cond_ok)
    );

    hpk_legal_chk #(
        .IDX_W   (IDX_W),
        .NUM_IDX (NUM_IDX),
        .PC_IDX  (PC_IDX),
        .SP_IDX  (SP_IDX)
    ) u_legal (
        .idx_flat (({rm_idx, rn_idx, rd_idx})),
        .compact  (compact_enc),
        .variant  (variant),
        .arith    (sh_is_asr),
        .illegal  (illegal_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            wr_en_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            wr_en_q   <= in_valid && cond_ok && !illegal_c;
            illegal_q <= in_valid && illegal_c;
            if (in_valid) begin
                res_q <= packed_c;
            end
        end
    end

    // R1: bottom-top keeps the low half of the first operand
    p_bt_keep_low_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pk_top_bot) |=> (res_q[HALF_W-1:0] == $past(src_a[HALF_W-1:0])));

    // R3: top-bottom keeps the high half of the first operand
    p_tb_keep_high_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pk_top_bot) |=> (res_q[DATA_W-1:HALF_W] == $past(src_a[DATA_W-1:HALF_W])));

    // R6: bottom-top with arithmetic shift type is illegal and blocks the write
    p_bt_asr_illegal_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pk_top_bot && sh_is_asr) |=> (illegal_q && !wr_en_q));

    // R7: destination index 15 is always illegal
    p_pc_dest_illegal_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (rd_idx == IDX_W'(PC_IDX))) |=> (illegal_q && !wr_en_q));

    // R10: an idle cycle drops the strobes and holds the result
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_en_q && !illegal_q && $stable(res_q)));

    // R10: a write is never committed alongside an illegal flag
    p_no_we_when_illegal_r10: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> !wr_en_q);

endmodule

// File: tb/hpk_unit_tb_top.sv
`timescale 1ns/1ps
module hpk_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] src_a, src_b;
    logic        pk_top_bot;
    logic [4:0]  sh_field;
    logic        sh_is_asr;
    logic [3:0]  cond_code, flags_nzcv;
    logic [3:0]  rd_idx, rn_idx, rm_idx;
    logic        compact_enc;
    logic [31:0] res_q;
    logic        wr_en_q, illegal_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_res;
    logic        m_we, m_ill;

    always #2.5 clk = ~clk;

    hpk_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .pk_top_bot(pk_top_bot),
        .sh_field(sh_field), .sh_is_asr(sh_is_asr),
        .cond_code(cond_code), .flags_nzcv(flags_nzcv),
        .rd_idx(rd_idx), .rn_idx(rn_idx), .rm_idx(rm_idx),
        .compact_enc(compact_enc),
        .res_q(res_q), .wr_en_q(wr_en_q), .illegal_q(illegal_q)
    );

    function automatic bit ref_cond(input int code, input logic [3:0] fl);
        bit n, z, c, v;
        n = fl[3]; z = fl[2]; c = fl[1]; v = fl[0];
        if (code == 0)  return z;
        if (code == 1)  return !z;
        if (code == 2)  return c;
        if (code == 3)  return !c;
        if (code == 4)  return n;
        if (code == 5)  return !n;
        if (code == 6)  return v;
        if (code == 7)  return !v;
        if (code == 8)  return c && !z;
        if (code == 9)  return !c || z;
        if (code == 10) return n == v;
        if (code == 11) return n != v;
        if (code == 12) return !z && (n == v);
        if (code == 13) return z || (n != v);
        return 1'b1;
    endfunction

    function automatic logic [31:0] ref_pack(input logic tb, input logic [31:0] a,
                                             input logic [31:0] b, input int sh);
        logic [63:0] wide;
        logic [31:0] r;
        int k;
        if (!tb) begin
            wide = {32'h0, b} << sh;
            r = {wide[31:16], a[15:0]};
        end else begin
            k = (sh == 0) ? 32 : sh;
            r[31:16] = a[31:16];
            for (int i = 0; i < 16; i++)
                r[i] = (i + k > 31) ? b[31] : b[i + k];
        end
        return r;
    endfunction

    function automatic bit ref_bad_idx(input logic [3:0] x, input logic cmp);
        return (x == 4'd15) || (cmp && x == 4'd13);
    endfunction

    task automatic tick(input string tag);
        bit ill;
        @(posedge clk);
        if (rst) begin
            m_res = 32'h0; m_we = 0; m_ill = 0;
        end else if (in_valid) begin
            ill = (!pk_top_bot && sh_is_asr) ||
                  ref_bad_idx(rd_idx, compact_enc) ||
                  ref_bad_idx(rn_idx, compact_enc) ||
                  ref_bad_idx(rm_idx, compact_enc);
            m_res = ref_pack(pk_top_bot, src_a, src_b, int'(sh_field));
            m_ill = ill;
            m_we  = !ill && ref_cond(int'(cond_code), flags_nzcv);
        end else begin
            m_we = 0; m_ill = 0;
        end
        @(negedge clk);
        n_checks++;
        if (res_q !== m_res || wr_en_q !== m_we || illegal_q !== m_ill) begin
            n_fail++;
            $display("FAIL %s: actual res=%h we=%b ill=%b expected res=%h we=%b ill=%b",
                     tag, res_q, wr_en_q, illegal_q, m_res, m_we, m_ill);
        end
    endtask

    task automatic set_op(input logic tb, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] sh, input logic asr);
        in_valid = 1; pk_top_bot = tb; src_a = a; src_b = b;
        sh_field = sh; sh_is_asr = asr;
        cond_code = 4'd14; flags_nzcv = 4'd0;
        rd_idx = 4'd0; rn_idx = 4'd1; rm_idx = 4'd2; compact_enc = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual no completion expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1;
        set_op(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 0);
        in_valid = 1;
        m_res = 0; m_we = 0; m_ill = 0;
        tick("R11 reset state");
        tick("R11 reset state");
        rst = 0;
        in_valid = 0;
        tick("R11 idle after reset");

        // R1 / R2 bottom-top
        set_op(0, 32'h1234_5678, 32'hABCD_EF01, 5'd8, 0);  tick("R1 lsl 8");
        set_op(0, 32'h1234_5678, 32'hABCD_EF01, 5'd0, 0);  tick("R2 lsl 0");
        set_op(0, 32'h1234_5678, 32'hABCD_EF01, 5'd16, 0); tick("R2 lsl 16");
        set_op(0, 32'h0F0F_A5A5, 32'h8000_0001, 5'd31, 0); tick("R1 lsl 31");

        // R3 / R4 top-bottom
        set_op(1, 32'h1234_5678, 32'hABCD_EF01, 5'd16, 1); tick("R3 asr 16");
        set_op(1, 32'h1234_5678, 32'h8000_0000, 5'd1, 1);  tick("R3 asr 1 negative");
        set_op(1, 32'hCAFE_0000, 32'h7654_3210, 5'd4, 1);  tick("R3 asr 4 positive");
        set_op(1, 32'h1111_2222, 32'h8765_4321, 5'd0, 1);  tick("R4 shift 32 negative");
        set_op(1, 32'h1111_2222, 32'h7FFF_FFFF, 5'd0, 1);  tick("R4 shift 32 positive");

        // R5 shift-type bit ignored in top-bottom
        set_op(1, 32'h2468_ACE0, 32'hF00D_BEEF, 5'd8, 0);  tick("R5 type bit 0");
        set_op(1, 32'h2468_ACE0, 32'hF00D_BEEF, 5'd8, 1);  tick("R5 type bit 1");

        // R6 bottom-top with ASR
        set_op(0, 32'h1357_9BDF, 32'h0246_8ACE, 5'd8, 1);  tick("R6 bt asr illegal");

        // R7 index 15
        set_op(1, 32'h1, 32'h2, 5'd3, 1); rd_idx = 4'd15; tick("R7 rd 15");
        set_op(1, 32'h1, 32'h2, 5'd3, 1); rn_idx = 4'd15; tick("R7 rn 15");
        set_op(0, 32'h1, 32'h2, 5'd3, 0); rm_idx = 4'd15; tick("R7 rm 15");

        // R8 index 13 depends on mode
        set_op(0, 32'h5, 32'h6, 5'd2, 0); rn_idx = 4'd13; tick("R8 13 legal");
        set_op(0, 32'h5, 32'h6, 5'd2, 0); rn_idx = 4'd13; compact_enc = 1; tick("R8 13 compact");
        set_op(1, 32'h5, 32'h6, 5'd2, 1); rd_idx = 4'd13; compact_enc = 1; tick("R8 rd 13 compact");
        set_op(1, 32'h5, 32'h6, 5'd2, 1); compact_enc = 1; tick("R8 compact no 13");

        // R9 condition table
        for (int cc = 0; cc < 16; cc++) begin
            for (int fl = 0; fl < 16; fl += 5) begin
                set_op(1, 32'h9999_0000 + cc, 32'h1234_0000 + fl, 5'd16, 1);
                cond_code = cc[3:0]; flags_nzcv = fl[3:0];
                tick("R9 condition");
            end
        end

        // R10 idle hold with changing inputs
        set_op(0, 32'hDEAD_BEEF, 32'h0123_4567, 5'd4, 0); tick("R10 load");
        in_valid = 0; src_a = 32'h0; src_b = 32'hFFFF_FFFF; tick("R10 hold");
        rd_idx = 4'd15; pk_top_bot = 0; sh_is_asr = 1; tick("R10 idle illegal ignored");
        set_op(0, 32'hDEAD_BEEF, 32'h0123_4567, 5'd4, 0); cond_code = 4'd0; tick("R10 cond fail loads result");

        // R11 reset mid run
        set_op(1, 32'hAAAA_5555, 32'h5555_AAAA, 5'd5, 1);
        rst = 1; tick("R11 mid-run reset");
        rst = 0; in_valid = 0; tick("R11 after reset");

        // random mix
        for (int i = 0; i < 400; i++) begin
            in_valid    = ($urandom_range(0, 3) != 0);
            src_a       = $urandom; src_b = $urandom;
            pk_top_bot  = 1'($urandom_range(0, 1));
            sh_field    = 5'($urandom_range(0, 31));
            sh_is_asr   = ($urandom_range(0, 5) == 0) ? 1'b1 : pk_top_bot;
            cond_code   = 4'($urandom_range(0, 15));
            flags_nzcv  = 4'($urandom_range(0, 15));
            rd_idx      = 4'($urandom_range(0, 15));
            rn_idx      = 4'($urandom_range(0, 12));
            rm_idx      = 4'($urandom_range(0, 14));
            compact_enc = 1'($urandom_range(0, 1));
            tick("R10 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule